// File: doc/BRIEF.md
# Compare-Match Output Pin Unit

This block sits next to a timer counter and owns the output side of one or more compare channels. Each channel holds an internal compare state bit that is rewritten whenever the counter's compare logic raises a match strobe. A 2-bit action field picks the new value: keep, invert, drive low or drive high. Software can also raise a force strobe that applies the same action without a real match, but only while the timer runs in a non-PWM waveform mode.

The same action field controls a general-purpose port pin. When the field is non-zero, the compare state replaces the port data bit as the pin's data source. The pin's direction bit still decides on its own whether the pin drives at all. The counter, the compare comparator and PWM waveform actions are outside this block. Matches always apply the non-PWM action table below.

Top module: `cmo_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, every channel's `cmp_state` becomes 0 at that edge.
- R2: Action field 00 leaves `cmp_state` unchanged on an update.
- R3: Action field 01 inverts `cmp_state` on an update.
- R4: Action field 10 makes `cmp_state` 0 on an update.
- R5: Action field 11 makes `cmp_state` 1 on an update.
- R6: A force strobe with `pwm_sel` low causes the same update as a match, at the same clock edge.
- R7: A force strobe with `pwm_sel` high has no effect on `cmp_state`.
- R8: A match and an allowed force strobe in the same cycle cause exactly one update, so an inversion happens once.
- R9: When the pin is an output and the channel's action field is non-zero, `pin_out` equals `cmp_state`. When the field is 00, `pin_out` equals `port_bit`. `pwm_sel` does not affect this choice.
- R10: `pin_oe` equals `dir_bit`. When `dir_bit` is 0, `pin_out` is 0 whatever the action field is.
- R11: The action field is used in the same cycle it is presented. It is not buffered: both the update at that edge and the pin source choice use it at once.
- R12: `cmp_state` holds its value in cycles with no update, including cycles where `pwm_sel` changes.
- R13: Each channel uses only its own strobes, action field (bits 2c+1:2c of `com_mode` for channel c), port bit and direction bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_sel | input | 1 | 1 when the timer runs a PWM waveform mode; blocks force strobes |
| match_stb | input | NUM_CH | Single-cycle compare-match pulse per channel |
| force_stb | input | NUM_CH | Single-cycle software force pulse per channel |
| com_mode | input | 2*NUM_CH | Action field per channel, two bits each |
| port_bit | input | NUM_CH | Port data register bit per channel |
| dir_bit | input | NUM_CH | Direction bit per channel, 1 = output |
| pin_out | output | NUM_CH | Data value presented to the pin |
| pin_oe | output | NUM_CH | Pin output enable |
| cmp_state | output | NUM_CH | Internal compare state per channel |

## Verification
The hardest case to reach is a match and a permitted force landing in the same cycle while the action field is changed in that very cycle. In that case one inversion, not two, must result, and it must follow the new field. The bench first loads a known compare state through a forced set or clear. It then presents the new field together with every match/force pairing under both `pwm_sel` values. This happens for every field value and both starting states. The pin mux is swept across field, state, port bit and direction bit, and it is checked before any clock edge so that its immediate response is exposed.

// File: rtl/cmo_pkg.sv
package cmo_pkg;

    typedef enum logic [1:0] {
        COM_OFF    = 2'b00,
        COM_TOGGLE = 2'b01,
        COM_CLEAR  = 2'b10,
        COM_SET    = 2'b11
    } com_mode_e;

    typedef struct packed {
        logic hit;
        logic frc;
    } strobe_t;

    function automatic logic com_next(com_mode_e mode, logic cur);
        logic nxt;
        case (mode)
            COM_TOGGLE: nxt = ~cur;
            COM_CLEAR:  nxt = 1'b0;
            COM_SET:    nxt = 1'b1;
            default:    nxt = cur;
        endcase
        return nxt;
    endfunction

    function automatic logic strobe_fires(strobe_t s, logic pwm);
        return s.hit | (s.frc & ~pwm);
    endfunction

endpackage

// File: rtl/cmo_chan_state.sv
module cmo_chan_state
    import cmo_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pwm_sel,
    input  strobe_t   stb,
    input  com_mode_e mode,
    output logic      state
);

    logic upd;

    always_comb begin
        upd = strobe_fires(stb, pwm_sel);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= 1'b0;
        end else if (upd) begin
            state <= com_next(mode, state);
        end
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> !state);

    a_r2_off_holds: assert property (@(posedge clk) disable iff (rst)
        (stb.hit && mode == COM_OFF) |=> $stable(state));

    a_r3_toggle_flips: assert property (@(posedge clk) disable iff (rst)
        (stb.hit && mode == COM_TOGGLE) |=> state != $past(state));

    a_r4_clear_low: assert property (@(posedge clk) disable iff (rst)
        (stb.hit && mode == COM_CLEAR) |=> !state);

    a_r5_set_high: assert property (@(posedge clk) disable iff (rst)
        ((stb.hit || (stb.frc && !pwm_sel)) && mode == COM_SET) |=> state);

    a_r7_force_blocked: assert property (@(posedge clk) disable iff (rst)
        (!stb.hit && pwm_sel) |=> $stable(state));

    a_r8_single_toggle: assert property (@(posedge clk) disable iff (rst)
        (stb.hit && stb.frc && !pwm_sel && mode == COM_TOGGLE) |=> state != $past(state));

    a_r12_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!stb.hit && !stb.frc) |=> $stable(state));

endmodule

// File: rtl/cmo_pin_mux.sv
module cmo_pin_mux
    import cmo_pkg::*;
(
    input  com_mode_e mode,
    input  logic      cmp,
    input  logic      port_bit,
    input  logic      dir_bit,
    output logic      pin_out,
    output logic      pin_oe
);

    logic src;

    always_comb begin
        src     = (mode != COM_OFF) ? cmp : port_bit;
        pin_oe  = dir_bit;
        pin_out = dir_bit ? src : 1'b0;
    end

endmodule

// File: rtl/cmo_unit.sv
module cmo_unit
    import cmo_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pwm_sel,
    input  logic [NUM_CH-1:0]     match_stb,
    input  logic [NUM_CH-1:0]     force_stb,
    input  logic [2*NUM_CH-1:0]   com_mode,
    input  logic [NUM_CH-1:0]     port_bit,
    input  logic [NUM_CH-1:0]     dir_bit,
    output logic [NUM_CH-1:0]     pin_out,
    output logic [NUM_CH-1:0]     pin_oe,
    output logic [NUM_CH-1:0]     cmp_state
);

    localparam int MODE_W = 2;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        com_mode_e mode_c;
        strobe_t   stb_c;

        always_comb begin
            mode_c    = com_mode_e'(com_mode[MODE_W*c +: MODE_W]);
            stb_c.hit = match_stb[c];
            stb_c.frc = force_stb[c];
        end

        cmo_chan_state u_state (
            .clk     (clk),
            .rst     (rst),
            .pwm_sel (pwm_sel),
            .stb     (stb_c),
            .mode    (mode_c),
            .state   (cmp_state[c])
        );

        cmo_pin_mux u_mux (
            .mode     (mode_c),
            .cmp      (cmp_state[c]),
            .port_bit (port_bit[c]),
            .dir_bit  (dir_bit[c]),
            .pin_out  (pin_out[c]),
            .pin_oe   (pin_oe[c])
        );

        a_r9_pin_follows_cmp: assert property (@(posedge clk) disable iff (rst)
            (dir_bit[c] && mode_c != COM_OFF) |-> pin_out[c] == cmp_state[c]);

        a_r9_pin_follows_port: assert property (@(posedge clk) disable iff (rst)
            (dir_bit[c] && mode_c == COM_OFF) |-> pin_out[c] == port_bit[c]);

        a_r10_released: assert property (@(posedge clk) disable iff (rst)
            !dir_bit[c] |-> (!pin_oe[c] && !pin_out[c]));
    end

endmodule

// File: tb/cmo_unit_tb.sv
module cmo_unit_tb;

    localparam int N = 2;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           pwm_sel = 1'b0;
    logic [N-1:0]   match_stb = '0;
    logic [N-1:0]   force_stb = '0;
    logic [2*N-1:0] com_mode = '0;
    logic [N-1:0]   port_bit = '0;
    logic [N-1:0]   dir_bit = '0;
    logic [N-1:0]   pin_out, pin_oe, cmp_state;

    logic [N-1:0]   exp_st = '0;
    int             n_chk = 0;
    int             n_fail = 0;
    bit             done = 1'b0;

    always #5 clk = ~clk;

    cmo_unit #(.NUM_CH(N)) u_dut (
        .clk(clk), .rst(rst), .pwm_sel(pwm_sel),
        .match_stb(match_stb), .force_stb(force_stb), .com_mode(com_mode),
        .port_bit(port_bit), .dir_bit(dir_bit),
        .pin_out(pin_out), .pin_oe(pin_oe), .cmp_state(cmp_state)
    );

    function automatic logic model_next(logic [1:0] m, logic cur);
        case (m)
            2'b01:   return ~cur;
            2'b10:   return 1'b0;
            2'b11:   return 1'b1;
            default: return cur;
        endcase
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
        end
    endtask

    // Clock one edge with the inputs now applied, then check the compare states.
    task automatic tick(string req);
        logic [N-1:0] strobed = '0;
        for (int c = 0; c < N; c++) begin
            if (rst) begin
                exp_st[c] = 1'b0;
            end else if (match_stb[c] || (force_stb[c] && !pwm_sel)) begin
                exp_st[c] = model_next(com_mode[2*c +: 2], exp_st[c]);
            end
            strobed[c] = match_stb[c] | force_stb[c];
        end
        @(posedge clk);
        #1;
        for (int c = 0; c < N; c++) begin
            chk(cmp_state[c] === exp_st[c], strobed[c] ? req : "R12/R13",
                int'(cmp_state[c]), int'(exp_st[c]));
        end
        @(negedge clk);
        match_stb = '0;
        force_stb = '0;
    endtask

    task automatic check_pins(string req);
        for (int c = 0; c < N; c++) begin
            logic ep;
            ep = dir_bit[c] ? ((com_mode[2*c +: 2] != 2'b00) ? exp_st[c] : port_bit[c]) : 1'b0;
            chk(pin_oe[c] === dir_bit[c], "R10", int'(pin_oe[c]), int'(dir_bit[c]));
            chk(pin_out[c] === ep, req, int'(pin_out[c]), int'(ep));
        end
    endtask

    // Load a known state in one channel with a forced set or clear (R6).
    task automatic preload(int ch, logic s);
        pwm_sel = 1'b0;
        com_mode[2*ch +: 2] = s ? 2'b11 : 2'b10;
        force_stb[ch] = 1'b1;
        tick("R6");
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick("R1");
        tick("R1");
        rst = 1'b0;
        for (int c = 0; c < N; c++)
            chk(cmp_state[c] === 1'b0, "R1", int'(cmp_state[c]), 0);

        // Update sweep: action, start state, match/force pairing, pwm_sel.
        for (int ch = 0; ch < N; ch++) begin
            for (int m = 0; m < 4; m++) begin
                for (int s = 0; s < 2; s++) begin
                    for (int hf = 0; hf < 4; hf++) begin
                        for (int pw = 0; pw < 2; pw++) begin
                            string req;
                            preload(ch, s[0]);
                            com_mode[2*ch +: 2] = m[1:0];
                            pwm_sel = pw[0];
                            match_stb[ch] = hf[0];
                            force_stb[ch] = hf[1];
                            if (hf == 3 && pw == 0)      req = "R8/R11";
                            else if (hf == 2 && pw == 1) req = "R7";
                            else if (hf == 2)            req = "R6/R11";
                            else if (m == 0)             req = "R2";
                            else if (m == 1)             req = "R3";
                            else if (m == 2)             req = "R4";
                            else                         req = "R5";
                            tick(req);
                        end
                    end
                end
            end
        end

        // Pin mux sweep, checked before any clock edge.
        for (int ch = 0; ch < N; ch++) begin
            for (int m = 0; m < 4; m++) begin
                for (int s = 0; s < 2; s++) begin
                    for (int pd = 0; pd < 4; pd++) begin
                        preload(ch, s[0]);
                        com_mode[2*ch +: 2] = m[1:0];
                        port_bit[ch] = pd[0];
                        dir_bit[ch] = pd[1];
                        #1;
                        check_pins(pd[1] ? "R9/R11" : "R10");
                        pwm_sel = 1'b1;
                        #1;
                        check_pins("R9");
                        pwm_sel = 1'b0;
                    end
                end
            end
        end

        // State held across pwm_sel changes with no strobes (R12).
        preload(0, 1'b1);
        preload(1, 1'b0);
        for (int k = 0; k < 4; k++) begin
            pwm_sel = k[0];
            tick("R12");
        end

        // Cross-channel isolation: strobe channel 0 only (R13).
        com_mode = 4'b0101;
        match_stb[0] = 1'b1;
        tick("R13");

        // Reset in mid-run clears a set state (R1).
        preload(0, 1'b1);
        preload(1, 1'b1);
        rst = 1'b1;
        tick("R1");
        rst = 1'b0;
        for (int c = 0; c < N; c++)
            chk(cmp_state[c] === 1'b0, "R1", int'(cmp_state[c]), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule